// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter

This block takes 24-bit left/right sample pairs from a parallel stream and shifts them out on a three-wire audio port: a bit clock, a frame clock and a data line. Each channel occupies a half-frame of 32 bit-clock periods. A static format pin picks between two framings. In left-justified framing the first bit follows the frame-clock edge at once, and the frame clock is high for the left channel. In I2S framing the first bit comes one bit period after the edge, and the frame clock is low for the left channel. The 24 data bits go out MSB first. The unused bit slots are driven low.

With `master_mode` high, the block generates the bit and frame clocks itself from `clk`. `clk` is taken as a master clock at 256 times the sample rate, so the bit clock is `clk`/4 and the frame clock is `clk`/256. With `master_mode` low, the block follows a bit clock and a frame clock from outside. It oversamples them with `clk` through synchronizers, and its own clock outputs stay low. The data line changes only on bit-clock falling edges, so a receiver can sample it on rising edges.

Samples arrive over a valid/ready handshake into a one-pair holding register. `s_ready` is high exactly while that register is empty. A pair moves from the register into transmission at the next frame boundary, which is the start of a left half. The source therefore sees back-pressure of up to one frame while a pair waits. If the register is empty at a boundary, the pair already in transmission is sent again.

Top module: `aud_serial_tx`

## Requirements
- R1: During and right after reset, `sdata` and `sclk_o` are low and `s_ready` is high. In master left-justified mode `lrck_o` starts high, at the left level.
- R2: In master mode `sclk_o` has a period of 4 `clk` cycles (2 high, 2 low). `lrck_o` toggles every 128 `clk` cycles and changes only on the `clk` edge where `sclk_o` falls.
- R3: With `fmt_i2s` low, the left half is the one with `lrck_o` high. In each half, bit slots 0 to 23 carry word bits 23 down to 0. Slot 0 is the first bit period after the frame-clock edge, and the left word goes before the right word.
- R4: With `fmt_i2s` high, the left half is the one with `lrck_o` low. Slot 0 is low and word bits 23 down to 0 occupy slots 1 to 24.
- R5: Every slot of a 32-slot half that carries no word bit is driven low. These are slots 24 to 31 in left-justified framing, and slots 0 and 25 to 31 in I2S framing.
- R6: In master mode `sdata` changes only on the `clk` edge where `sclk_o` falls.
- R7: `s_ready` is high exactly while the holding register is empty. A transfer (`s_valid` and `s_ready` high at a rising edge) drops `s_ready` in the next cycle. The held pair enters transmission at the next frame boundary, after which `s_ready` rises again. Pairs are sent in the order they were accepted.
- R8: If no pair is held at a frame boundary, the previous pair is sent again. Until the first pair arrives, all-zero words are sent.
- R9: In slave mode `sclk_o` and `lrck_o` stay low. `sclk_i` and `lrck_i` pass through two synchronizer stages. A change of `lrck_i` seen at a falling `sclk_i` edge starts slot 0 of a new half, and the start of a left half is the frame boundary. `sdata` follows each `sclk_i` fall within 3 `clk` cycles, so `sclk_i` must stay at each level for at least 8 `clk` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 256x the sample rate in master mode |
| rst_n | input | 1 | Active-low synchronous reset |
| master_mode | input | 1 | Static: 1 generates the clocks, 0 follows external ones |
| fmt_i2s | input | 1 | Static: 0 left-justified, 1 I2S framing |
| s_valid | input | 1 | Sample pair on `s_left`/`s_right` is valid |
| s_ready | output | 1 | Holding register empty, pair accepted on this edge if valid |
| s_left | input | 24 | Left channel sample |
| s_right | input | 24 | Right channel sample |
| sclk_i | input | 1 | External bit clock (slave mode) |
| lrck_i | input | 1 | External frame clock (slave mode) |
| sclk_o | output | 1 | Generated bit clock (master mode, else low) |
| lrck_o | output | 1 | Generated frame clock (master mode, else low) |
| sdata | output | 1 | Serial data, changes on bit-clock falling edges |

## Verification
A wrong slot count or a wrong format offset shifts the recovered word by one or more bit positions. The bench sees this at the end of the first complete half-frame that carries data, at most three frames after the pair is loaded. A fault in the holding register or the boundary detect shows up as a repeated or skipped pair in the next frame, or as `s_ready` staying low for longer than one frame. A divider fault disturbs the clock periods within one bit period or one half-frame, and the checker reports it on that cycle.

// File: rtl/aud_ser_pkg.sv
package aud_ser_pkg;

  // One bit-clock falling-edge event, shared by the master and slave timing paths.
  typedef struct packed {
    logic tick;       // a falling bit-clock edge happens on this clk edge
    logic new_half;   // the slot that follows is slot 0 of a new half
    logic left_next;  // that new half belongs to the left channel
  } slot_evt_t;

endpackage

// File: rtl/aud_mclk_div.sv
module aud_mclk_div
  import aud_ser_pkg::*;
#(
  parameter int MDIV  = 4,   // clk cycles per bit period (power of two, >= 2)
  parameter int SLOTS = 32   // bit periods per half-frame (power of two)
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      fmt_i2s,
  output logic      sclk,
  output logic      lrck,
  output slot_evt_t evt
);
  localparam int DW = $clog2(MDIV);
  localparam int SW = $clog2(SLOTS);
  localparam int CW = DW + SW + 1;

  logic [CW-1:0] cnt;
  logic [DW-1:0] sub;
  logic [SW-1:0] slot;
  logic          half;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  assign sub  = cnt[DW-1:0];
  assign slot = cnt[DW+SW-1:DW];
  assign half = cnt[CW-1];

  // Last clk of a bit period: the next edge lowers sclk.
  assign evt.tick      = &sub;
  assign evt.new_half  = (&sub) & (&slot);
  assign evt.left_next = half;   // leaving the right half means a left half follows

  assign sclk = sub[DW-1];
  assign lrck = fmt_i2s ? half : ~half;

endmodule

// File: rtl/aud_slave_sync.sv
module aud_slave_sync
  import aud_ser_pkg::*;
#(
  parameter int STAGES = 2   // synchronizer depth, >= 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      fmt_i2s,
  input  logic      sclk_i,
  input  logic      lrck_i,
  output slot_evt_t evt
);
  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] sck_sh;
  logic [STAGES-1:0] lr_sh;
  logic              sck_d;
  logic              lr_last;
  logic              fall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_sh  <= '0;
      lr_sh   <= '0;
      sck_d   <= 1'b0;
      lr_last <= 1'b0;
    end else begin
      sck_sh <= {sck_sh[STAGES-2:0], sclk_i};
      lr_sh  <= {lr_sh[STAGES-2:0], lrck_i};
      sck_d  <= sck_sh[TOP];
      if (fall) lr_last <= lr_sh[TOP];
    end
  end

  assign fall          = sck_d & ~sck_sh[TOP];
  assign evt.tick      = fall;
  assign evt.new_half  = fall & (lr_sh[TOP] != lr_last);
  assign evt.left_next = (lr_sh[TOP] == ~fmt_i2s);

endmodule

// File: rtl/aud_pair_buf.sv
module aud_pair_buf #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_left,
  input  logic [W-1:0] s_right,
  input  logic         frame_start,
  output logic [W-1:0] nxt_left,
  output logic [W-1:0] nxt_right
);
  logic [W-1:0] hold_l, hold_r, tx_l, tx_r;
  logic         full;
  logic         load;

  assign s_ready = ~full;
  assign load    = frame_start & full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full   <= 1'b0;
      hold_l <= '0;
      hold_r <= '0;
      tx_l   <= '0;
      tx_r   <= '0;
    end else if (load) begin
      tx_l <= hold_l;
      tx_r <= hold_r;
      full <= 1'b0;
    end else if (s_valid && !full) begin
      hold_l <= s_left;
      hold_r <= s_right;
      full   <= 1'b1;
    end
  end

  // On a loading edge the shifter already needs the incoming pair.
  assign nxt_left  = load ? hold_l : tx_l;
  assign nxt_right = load ? hold_r : tx_r;

endmodule

// File: rtl/aud_slot_shifter.sv
module aud_slot_shifter
  import aud_ser_pkg::*;
#(
  parameter int W     = 24,
  parameter int SLOTS = 32   // must exceed W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fmt_i2s,
  input  slot_evt_t    evt,
  input  logic [W-1:0] nxt_left,
  input  logic [W-1:0] nxt_right,
  output logic         frame_start,
  output logic         sdata
);
  localparam int SW = $clog2(SLOTS);
  localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

  logic [SW-1:0] slot_q, slot_n, rel, off;
  logic          left_q, left_n, in_rng, bit_n;
  logic [W-1:0]  word, shifted;

  assign frame_start = evt.tick & evt.new_half & evt.left_next;

  always_comb begin
    if (evt.new_half)        slot_n = '0;
    else if (slot_q == LAST) slot_n = LAST;
    else                     slot_n = slot_q + 1'b1;
    left_n  = evt.new_half ? evt.left_next : left_q;
    off     = {{(SW-1){1'b0}}, fmt_i2s};
    rel     = slot_n - off;
    in_rng  = (slot_n >= off) && (32'(rel) < W);
    word    = left_n ? nxt_left : nxt_right;
    shifted = word << rel;
    bit_n   = in_rng & shifted[W-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q <= LAST;
      left_q <= 1'b1;
      sdata  <= 1'b0;
    end else if (evt.tick) begin
      slot_q <= slot_n;
      left_q <= left_n;
      sdata  <= bit_n;
    end
  end

endmodule

// File: rtl/aud_serial_tx.sv
module aud_serial_tx
  import aud_ser_pkg::*;
#(
  parameter int WORD_W      = 24,
  parameter int SLOTS       = 32,
  parameter int MDIV        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_mode,
  input  logic              fmt_i2s,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [WORD_W-1:0] s_left,
  input  logic [WORD_W-1:0] s_right,
  input  logic              sclk_i,
  input  logic              lrck_i,
  output logic              sclk_o,
  output logic              lrck_o,
  output logic              sdata
);
  slot_evt_t         m_evt, s_evt, evt;
  logic              m_sclk, m_lrck, frame_start;
  logic [WORD_W-1:0] nxt_left, nxt_right;

  aud_mclk_div #(.MDIV(MDIV), .SLOTS(SLOTS)) u_div (
    .clk(clk), .rst_n(rst_n), .fmt_i2s(fmt_i2s),
    .sclk(m_sclk), .lrck(m_lrck), .evt(m_evt)
  );

  aud_slave_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .fmt_i2s(fmt_i2s),
    .sclk_i(sclk_i), .lrck_i(lrck_i), .evt(s_evt)
  );

  assign evt    = master_mode ? m_evt : s_evt;
  assign sclk_o = master_mode & m_sclk;
  assign lrck_o = master_mode & m_lrck;

  aud_pair_buf #(.W(WORD_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_left(s_left), .s_right(s_right), .frame_start(frame_start),
    .nxt_left(nxt_left), .nxt_right(nxt_right)
  );

  aud_slot_shifter #(.W(WORD_W), .SLOTS(SLOTS)) u_shift (
    .clk(clk), .rst_n(rst_n), .fmt_i2s(fmt_i2s), .evt(evt),
    .nxt_left(nxt_left), .nxt_right(nxt_right),
    .frame_start(frame_start), .sdata(sdata)
  );

endmodule

// File: rtl/aud_serial_tx_chk.sv
module aud_serial_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic master_mode,
  input logic s_valid,
  input logic s_ready,
  input logic sclk_o,
  input logic lrck_o,
  input logic sdata
);
  p_sclk_high_two_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && $rose(sclk_o)) |=> sclk_o);

  p_sclk_low_two_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && $fell(sclk_o)) |=> !sclk_o);

  p_lrck_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && !$stable(lrck_o)) |-> $fell(sclk_o));

  p_data_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && !$stable(sdata)) |-> $fell(sclk_o));

  p_ready_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready);

  p_slave_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !master_mode |-> (!sclk_o && !lrck_o));

endmodule

bind aud_serial_tx aud_serial_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .master_mode(master_mode), .s_valid(s_valid),
  .s_ready(s_ready), .sclk_o(sclk_o), .lrck_o(lrck_o), .sdata(sdata)
);

// File: tb/aud_serial_tx_bench.sv
`timescale 1ns/100ps
module aud_serial_tx_bench;
  logic        clk = 1'b0, rst_n = 1'b0, master_mode = 1'b1, fmt_i2s = 1'b0;
  logic        s_valid = 1'b0, sclk_i = 1'b1, lrck_i = 1'b0;
  logic [23:0] s_left = '0, s_right = '0;
  logic        s_ready, sclk_o, lrck_o, sdata;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  aud_serial_tx u_aud_serial_tx (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode), .fmt_i2s(fmt_i2s),
    .s_valid(s_valid), .s_ready(s_ready), .s_left(s_left), .s_right(s_right),
    .sclk_i(sclk_i), .lrck_i(lrck_i), .sclk_o(sclk_o), .lrck_o(lrck_o), .sdata(sdata)
  );

  // {master, i2s, left, right}
  localparam logic [49:0] VEC [6] = '{
    {1'b1, 1'b0, 24'hA5A5A5, 24'h5A5A5A},
    {1'b1, 1'b1, 24'h800001, 24'h7FFFFE},
    {1'b1, 1'b0, 24'hFFFFFF, 24'h000000},
    {1'b1, 1'b1, 24'h123456, 24'hFEDCBA},
    {1'b0, 1'b0, 24'hC0FFEE, 24'h0BEEF1},
    {1'b0, 1'b1, 24'h800000, 24'h000001}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] frame_of(input logic [23:0] w, input logic f);
    return f ? {1'b0, w, 7'b0} : {w, 8'b0};
  endfunction

  // Serial receiver: samples on the rising bit clock, splits halves at frame-clock changes.
  wire rx_sclk = master_mode ? sclk_o : sclk_i;
  wire rx_lr   = master_mode ? lrck_o : lrck_i;
  logic [31:0] rx_sh, cap_l, cap_r;
  int          rx_n, rx_rights;
  logic        rx_prev, rx_first;

  always @(posedge rx_sclk or negedge rst_n) begin
    if (!rst_n) begin
      rx_first = 1; rx_n = 0; rx_rights = 0; rx_sh = '0; cap_l = '0; cap_r = '0; rx_prev = 0;
    end else begin
      if (!rx_first && rx_lr != rx_prev) begin
        if (rx_n == 32) begin
          if (rx_prev == ~fmt_i2s) cap_l = rx_sh;
          else begin cap_r = rx_sh; rx_rights++; end
        end
        rx_sh = {31'b0, sdata};
        rx_n  = 1;
      end else begin
        rx_sh = {rx_sh[30:0], sdata};
        rx_n++;
      end
      rx_first = 0;
      rx_prev  = rx_lr;
    end
  end

  // R6 monitor: data may move only together with a falling bit clock.
  logic prev_sd = 0, prev_sck = 0;
  int   r6_bad = 0;
  always @(negedge clk) begin
    if (rst_n && master_mode && sdata !== prev_sd && !(prev_sck && !sclk_o)) r6_bad++;
    prev_sd  = sdata;
    prev_sck = sclk_o;
  end

  task automatic do_reset(input logic m, input logic f);
    @(negedge clk);
    rst_n = 0; master_mode = m; fmt_i2s = f; s_valid = 0;
    sclk_i = 1; lrck_i = f;
    repeat (4) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic push(input logic [23:0] l, input logic [23:0] r);
    @(negedge clk);
    s_valid = 1; s_left = l; s_right = r;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 0;
  endtask

  task automatic wait_rights(input int n);
    while (rx_rights < n) @(negedge clk);
  endtask

  task automatic slave_frames(input int n, input logic f);
    for (int fr = 0; fr < n; fr++)
      for (int h = 0; h < 2; h++)
        for (int s = 0; s < 32; s++) begin
          @(negedge clk);
          sclk_i = 0;
          if (s == 0) lrck_i = (h == 0) ? ~f : f;
          repeat (8) @(negedge clk);
          sclk_i = 1;
          repeat (7) @(negedge clk);
        end
  endtask

  initial begin
    int c;
    logic lv;
    // R1: reset state
    do_reset(1'b1, 1'b0);
    @(negedge clk);
    chk(sdata == 0, "R1 sdata", 32'(sdata), 0);
    chk(s_ready == 1, "R1 s_ready", 32'(s_ready), 1);
    chk(sclk_o == 0, "R1 sclk_o", 32'(sclk_o), 0);
    chk(lrck_o == 1, "R1 lrck_o", 32'(lrck_o), 1);

    // R2: clock rates
    lv = lrck_o;
    while (lrck_o == lv) @(negedge clk);
    c = 0; lv = lrck_o;
    while (lrck_o == lv) begin @(negedge clk); c++; end
    chk(c == 128, "R2 lrck half period", 32'(c), 128);
    while (sclk_o) @(negedge clk);
    while (!sclk_o) @(negedge clk);
    c = 0;
    while (sclk_o) begin @(negedge clk); c++; end
    while (!sclk_o) begin @(negedge clk); c++; end
    chk(c == 4, "R2 sclk period", 32'(c), 4);

    // Vector table: both formats, both clocking modes
    for (int i = 0; i < 6; i++) begin
      logic m, f;
      logic [23:0] l, r;
      string tag;
      {m, f, l, r} = VEC[i];
      tag = f ? "R4 R5" : "R3 R5";
      do_reset(m, f);
      push(l, r);
      if (m) wait_rights(3);
      else begin
        slave_frames(4, f);
        chk(sclk_o == 0 && lrck_o == 0, "R9 clock outputs idle", {sclk_o, lrck_o}, 0);
        tag = {tag, " R9"};
      end
      @(negedge clk);
      chk(cap_l == frame_of(l, f), {tag, " left"}, cap_l, frame_of(l, f));
      chk(cap_r == frame_of(r, f), {tag, " right"}, cap_r, frame_of(r, f));
    end

    // R7 / R8: back-pressure, ordering, repetition
    do_reset(1'b1, 1'b0);
    push(24'h111111, 24'h222222);
    chk(s_ready == 0, "R7 ready low while held", 32'(s_ready), 0);
    push(24'h333333, 24'h444444);
    chk(s_ready == 0, "R7 second pair held", 32'(s_ready), 0);
    wait_rights(2);
    @(negedge clk);
    chk(cap_l == frame_of(24'h111111, 0), "R7 first pair first", cap_l, frame_of(24'h111111, 0));
    wait_rights(3);
    @(negedge clk);
    chk(cap_l == frame_of(24'h333333, 0), "R7 second pair next", cap_l, frame_of(24'h333333, 0));
    chk(s_ready == 1, "R7 ready back after load", 32'(s_ready), 1);
    wait_rights(5);
    @(negedge clk);
    chk(cap_r == frame_of(24'h444444, 0), "R8 pair repeated", cap_r, frame_of(24'h444444, 0));

    chk(r6_bad == 0, "R6 sdata moves only on sclk fall", 32'(r6_bad), 0);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule